// File: doc/BRIEF.md
# PS/2 Matrix Keyboard Emulator

This block turns serial PS/2 keyboard traffic into the state of a 10-column by 8-row key matrix of the kind a legacy home computer scans. A host selects one matrix position with a 4-bit column select and a 3-bit row select, and reads back whether that key is held. A second output raises whenever any key outside row 0 is down. A dedicated BREAK key sits outside the matrix and drives its own output. Eight configuration switches appear as keys in row 0.

When the host sets autoscan, an internal column counter replaces the column select. The counter steps once per 1 MHz clock enable, so a scanning host only has to drive the row. The reset input should come from the power-on reset only, so that the BREAK output can reset the rest of a system without clearing the keyboard's own state.

Top module: `kbm_top`

## Requirements
- R1: A PS/2 frame is taken on falling edges of the synchronised PS/2 clock. It has a start bit of 0, eight data bits LSB first, an odd parity bit and a stop bit of 1. A valid code updates the matrix through this map (set 2 codes): 0x1C→row 4 col 1, 0x32→row 6 col 4, 0x21→row 5 col 2, 0x29→row 6 col 2, 0x5A→row 4 col 9, 0x76→row 7 col 0, 0x16→row 3 col 0, 0x12→row 0 col 0, 0x14→row 0 col 1, 0xE0 0x75→row 3 col 9, 0x07→BREAK. Any other code has no effect.
- R2: A frame with wrong parity or a stop bit of 0 is discarded and changes no key.
- R3: If no PS/2 clock falling edge arrives for TIMEOUT_CYC clock cycles, the bit counter returns to zero, so a cut-off frame does not corrupt the next one.
- R4: A code preceded by 0xF0 releases its key instead of pressing it.
- R5: A code preceded by 0xE0 is looked up as an extended code, separate from the same byte without the prefix (plain 0x75 is unmapped). 0xE0 0xF0 followed by a code releases the extended key.
- R6: With autoscan low, `key_hit` is 1 exactly when the key at `row_sel`/`col_sel` is held. Column values 10 to 15 always read 0.
- R7: With autoscan high, `col_sel` is ignored and an internal column counter selects the column. The counter advances by one on each cycle with `clken_1m` high and goes from 9 back to 0. With autoscan low, the counter holds its value.
- R8: `any_key_irq` is 1 whenever at least one matrix key in rows 1 to 7 is held. Keys in row 0 never raise it.
- R9: `break_key` is 1 while the BREAK key is held. That key never shows in the matrix and never raises `any_key_irq`.
- R10: Row 0, columns 2 to 9 read the switch input: column c reads `dip_sw[9-c]`, so column 2 reads bit 7 and column 9 reads bit 0.
- R11: Synchronous `rst` releases every key, clears `break_key`, sets the scan column to 0 and drops any pending prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clken_1m | input | 1 | 1 MHz clock enable for the scan counter |
| ps2_clk | input | 1 | PS/2 clock line (asynchronous) |
| ps2_dat | input | 1 | PS/2 data line (asynchronous) |
| autoscan | input | 1 | 1: internal counter selects the column |
| col_sel | input | 4 | Column select from the host |
| row_sel | input | 3 | Row select from the host |
| dip_sw | input | 8 | Configuration switches, shown in row 0 |
| key_hit | output | 1 | Selected key is held |
| any_key_irq | output | 1 | Some key in rows 1 to 7 is held |
| break_key | output | 1 | BREAK key is held |

## Verification
The bench builds the block with TIMEOUT_CYC set to 100 and drives PS/2 bits with a 20-cycle half period. The stall in the timeout scenario therefore lasts a few hundred cycles, not the thousands a 100 µs default would need. With the timeout set this short, a cut-off frame followed by a clean one shows within a short run whether the receiver recovers. Each autoscan check is a handful of single-cycle clock-enable pulses, so a full wrap of the ten columns costs only tens of cycles.

// File: rtl/kbm_pkg.sv
package kbm_pkg;

    localparam int KB_COLS   = 10;
    localparam int KB_ROWS   = 8;
    localparam int COL_W     = 4;
    localparam int ROW_W     = 3;
    localparam int KB_KEYS   = KB_COLS * KB_ROWS;
    localparam int KEY_IDX_W = COL_W + ROW_W;
    localparam int DIP_COL0  = 2;
    localparam int DIP_W     = KB_COLS - DIP_COL0;
    localparam int FRAME_BITS = 11;

    localparam logic [7:0] PFX_RELEASE = 8'hF0;
    localparam logic [7:0] PFX_EXTEND  = 8'hE0;

    typedef struct packed {
        logic             hit;
        logic             brk;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } key_loc_t;

    function automatic key_loc_t key_at(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r);
        key_loc_t k;
        k.hit = 1'b1;
        k.brk = 1'b0;
        k.col = c;
        k.row = r;
        return k;
    endfunction

    function automatic key_loc_t scan_lookup(input logic ext, input logic [7:0] code);
        key_loc_t k;
        k = '0;
        case ({ext, code})
            9'h01C: k = key_at(4'd1, 3'd4);
            9'h032: k = key_at(4'd4, 3'd6);
            9'h021: k = key_at(4'd2, 3'd5);
            9'h029: k = key_at(4'd2, 3'd6);
            9'h05A: k = key_at(4'd9, 3'd4);
            9'h076: k = key_at(4'd0, 3'd7);
            9'h016: k = key_at(4'd0, 3'd3);
            9'h012: k = key_at(4'd0, 3'd0);
            9'h014: k = key_at(4'd1, 3'd0);
            9'h175: k = key_at(4'd9, 3'd3);
            9'h007: begin
                k.hit = 1'b1;
                k.brk = 1'b1;
            end
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/kbm_ps2_rx.sv
module kbm_ps2_rx
    import kbm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk,
    input  logic       ps2_dat,
    output logic       byte_vld,
    output logic [7:0] byte_dat
);

    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int BW = $clog2(FRAME_BITS);

    logic [1:0]            clk_sy;
    logic [1:0]            dat_sy;
    logic                  clk_prev;
    logic                  fall;
    logic [BW-1:0]         bit_cnt;
    logic [FRAME_BITS-2:0] shreg;
    logic [TW-1:0]         idle;
    logic                  frame_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sy   <= 2'b11;
            dat_sy   <= 2'b11;
            clk_prev <= 1'b1;
        end else begin
            clk_sy   <= {clk_sy[0], ps2_clk};
            dat_sy   <= {dat_sy[0], ps2_dat};
            clk_prev <= clk_sy[1];
        end
    end

    assign fall = clk_prev & ~clk_sy[1];

    // start low, stop high, odd count of ones across data and parity
    assign frame_ok = ~shreg[0] & dat_sy[1] & (^shreg[FRAME_BITS-2:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            idle     <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (fall) begin
                idle <= '0;
                if (bit_cnt == BW'(FRAME_BITS - 1)) begin
                    bit_cnt  <= '0;
                    byte_vld <= frame_ok;
                    byte_dat <= shreg[8:1];
                end else begin
                    shreg   <= {dat_sy[1], shreg[FRAME_BITS-2:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (idle != TW'(TIMEOUT_CYC)) begin
                idle <= idle + 1'b1;
            end else begin
                bit_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/kbm_matrix.sv
module kbm_matrix
    import kbm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_vld,
    input  logic [7:0]         byte_dat,
    output logic [KB_KEYS-1:0] keys,
    output logic               brk_held
);

    logic                 rel_pend;
    logic                 ext_pend;
    key_loc_t             loc;
    logic [KEY_IDX_W-1:0] idx;

    always_comb begin
        loc = scan_lookup(ext_pend, byte_dat);
        idx = {loc.col, loc.row};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            keys     <= '0;
            brk_held <= 1'b0;
            rel_pend <= 1'b0;
            ext_pend <= 1'b0;
        end else if (byte_vld) begin
            if (byte_dat == PFX_RELEASE) begin
                rel_pend <= 1'b1;
            end else if (byte_dat == PFX_EXTEND) begin
                ext_pend <= 1'b1;
            end else begin
                rel_pend <= 1'b0;
                ext_pend <= 1'b0;
                if (loc.hit) begin
                    if (loc.brk) brk_held  <= ~rel_pend;
                    else         keys[idx] <= ~rel_pend;
                end
            end
        end
    end

endmodule

// File: rtl/kbm_scan.sv
module kbm_scan
    import kbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clken_1m,
    input  logic             autoscan,
    output logic [COL_W-1:0] scan_col
);

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_col <= '0;
        end else if (autoscan && clken_1m) begin
            if (scan_col == COL_W'(KB_COLS - 1)) scan_col <= '0;
            else                                 scan_col <= scan_col + 1'b1;
        end
    end

endmodule

// File: rtl/kbm_top.sv
module kbm_top
    import kbm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clken_1m,
    input  logic             ps2_clk,
    input  logic             ps2_dat,
    input  logic             autoscan,
    input  logic [COL_W-1:0] col_sel,
    input  logic [ROW_W-1:0] row_sel,
    input  logic [DIP_W-1:0] dip_sw,
    output logic             key_hit,
    output logic             any_key_irq,
    output logic             break_key
);

    logic               byte_vld;
    logic [7:0]         byte_dat;
    logic [KB_KEYS-1:0] keys;
    logic [COL_W-1:0]   scan_col;
    logic [COL_W-1:0]   eff_col;
    logic [2:0]         dip_idx;
    logic [KB_COLS-1:0] col_act;

    kbm_ps2_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .ps2_clk  (ps2_clk),
        .ps2_dat  (ps2_dat),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat)
    );

    kbm_matrix u_mat (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat),
        .keys     (keys),
        .brk_held (break_key)
    );

    kbm_scan u_scan (
        .clk      (clk),
        .rst      (rst),
        .clken_1m (clken_1m),
        .autoscan (autoscan),
        .scan_col (scan_col)
    );

    assign eff_col = autoscan ? scan_col : col_sel;
    assign dip_idx = 3'(COL_W'(KB_COLS - 1) - eff_col);

    always_comb begin
        key_hit = 1'b0;
        if (eff_col < COL_W'(KB_COLS)) begin
            if (row_sel == '0 && eff_col >= COL_W'(DIP_COL0))
                key_hit = dip_sw[dip_idx];
            else
                key_hit = keys[{eff_col, row_sel}];
        end
    end

    for (genvar c = 0; c < KB_COLS; c++) begin : g_col
        assign col_act[c] = |keys[c*KB_ROWS+1 +: KB_ROWS-1];
    end

    assign any_key_irq = |col_act;

endmodule

// File: rtl/kbm_chk.sv
module kbm_chk
    import kbm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clken_1m,
    input logic             autoscan,
    input logic [COL_W-1:0] scan_col,
    input logic [COL_W-1:0] col_sel,
    input logic [ROW_W-1:0] row_sel,
    input logic [DIP_W-1:0] dip_sw,
    input logic             key_hit,
    input logic             any_key_irq,
    input logic             break_key
);

    // R7
    scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (autoscan && clken_1m && scan_col == 4'd9) |=> (scan_col == 4'd0));

    // R7
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !autoscan |=> $stable(scan_col));

    // R6
    col_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!autoscan && col_sel > 4'd9) |-> !key_hit);

    // R10
    dip_map_chk: assert property (@(posedge clk) disable iff (rst)
        (!autoscan && row_sel == 3'd0 && col_sel >= 4'd2 && col_sel <= 4'd9)
        |-> (key_hit == dip_sw[3'(4'd9 - col_sel)]));

    // R8
    irq_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (!autoscan && row_sel != 3'd0 && col_sel <= 4'd9 && key_hit) |-> any_key_irq);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!any_key_irq && !break_key));

endmodule

bind kbm_top kbm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clken_1m    (clken_1m),
    .autoscan    (autoscan),
    .scan_col    (scan_col),
    .col_sel     (col_sel),
    .row_sel     (row_sel),
    .dip_sw      (dip_sw),
    .key_hit     (key_hit),
    .any_key_irq (any_key_irq),
    .break_key   (break_key)
);

// File: tb/kbm_top_bench.sv
`timescale 1ns/1ps
module kbm_top_bench;

    localparam int HALF = 20;
    localparam int TMO  = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clken_1m = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       autoscan = 1'b0;
    logic [3:0] col_sel = '0;
    logic [2:0] row_sel = '0;
    logic [7:0] dip_sw = '0;
    logic       key_hit;
    logic       any_key_irq;
    logic       break_key;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kbm_top #(.TIMEOUT_CYC(TMO)) u_kbm_top (
        .clk         (clk),
        .rst         (rst),
        .clken_1m    (clken_1m),
        .ps2_clk     (ps2_clk),
        .ps2_dat     (ps2_dat),
        .autoscan    (autoscan),
        .col_sel     (col_sel),
        .row_sel     (row_sel),
        .dip_sw      (dip_sw),
        .key_hit     (key_hit),
        .any_key_irq (any_key_irq),
        .break_key   (break_key)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk) ps2_dat = v;
        repeat (HALF) @(negedge clk);
        ps2_clk = 1'b0;
        repeat (HALF) @(negedge clk);
        ps2_clk = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit((~^b) ^ bad_par);
        send_bit(~bad_stop);
        repeat (HALF) @(negedge clk);
    endtask

    task automatic probe(input logic [2:0] r, input logic [3:0] c, output logic v);
        @(negedge clk);
        row_sel = r;
        col_sel = c;
        #1 v = key_hit;
    endtask

    task automatic pulse_clken();
        @(negedge clk) clken_1m = 1'b1;
        @(negedge clk) clken_1m = 1'b0;
    endtask

    task automatic t_reset_state();
        logic v;
        probe(3'd4, 4'd1, v);
        check("R11 reset key", v, 1'b0);
        check("R11 reset irq", any_key_irq, 1'b0);
        check("R11 reset break", break_key, 1'b0);
    endtask

    task automatic t_press_release();
        logic v;
        send_byte(8'h1C);
        probe(3'd4, 4'd1, v);
        check("R1 press 0x1C", v, 1'b1);
        check("R8 irq on row 4", any_key_irq, 1'b1);
        probe(3'd4, 4'd2, v);
        check("R6 neighbour key", v, 1'b0);
        send_byte(8'h5A);
        probe(3'd4, 4'd9, v);
        check("R1 press 0x5A", v, 1'b1);
        send_byte(8'hF0); send_byte(8'h1C);
        probe(3'd4, 4'd1, v);
        check("R4 release 0x1C", v, 1'b0);
        probe(3'd4, 4'd9, v);
        check("R4 other key held", v, 1'b1);
        send_byte(8'hF0); send_byte(8'h5A);
        #1 check("R8 irq drops", any_key_irq, 1'b0);
    endtask

    task automatic t_bad_frames();
        logic v;
        send_byte(8'h1C, 1, 0);
        probe(3'd4, 4'd1, v);
        check("R2 bad parity", v, 1'b0);
        send_byte(8'h1C, 0, 1);
        probe(3'd4, 4'd1, v);
        check("R2 bad stop", v, 1'b0);
        send_byte(8'h32);
        probe(3'd6, 4'd4, v);
        check("R2 next frame ok", v, 1'b1);
        send_byte(8'hF0); send_byte(8'h32);
    endtask

    task automatic t_extended();
        logic v;
        send_byte(8'h75);
        probe(3'd3, 4'd9, v);
        check("R5 plain 0x75 unmapped", v, 1'b0);
        check("R5 plain irq", any_key_irq, 1'b0);
        send_byte(8'hE0); send_byte(8'h75);
        probe(3'd3, 4'd9, v);
        check("R5 extended press", v, 1'b1);
        send_byte(8'hE0); send_byte(8'hF0); send_byte(8'h75);
        probe(3'd3, 4'd9, v);
        check("R5 extended release", v, 1'b0);
    endtask

    task automatic t_row0_and_break();
        logic v;
        send_byte(8'h12);
        probe(3'd0, 4'd0, v);
        check("R1 shift row0 col0", v, 1'b1);
        check("R8 row0 no irq", any_key_irq, 1'b0);
        send_byte(8'hF0); send_byte(8'h12);
        send_byte(8'h07);
        #1 check("R9 break held", break_key, 1'b1);
        check("R9 break no irq", any_key_irq, 1'b0);
        probe(3'd0, 4'd0, v);
        check("R9 break not in matrix", v, 1'b0);
        send_byte(8'hF0); send_byte(8'h07);
        #1 check("R9 break released", break_key, 1'b0);
    endtask

    task automatic t_dip();
        logic v;
        dip_sw = 8'h81;
        probe(3'd0, 4'd2, v);
        check("R10 col2 bit7", v, 1'b1);
        probe(3'd0, 4'd9, v);
        check("R10 col9 bit0", v, 1'b1);
        probe(3'd0, 4'd3, v);
        check("R10 col3 bit6 low", v, 1'b0);
        dip_sw = 8'h40;
        probe(3'd0, 4'd3, v);
        check("R10 col3 bit6 high", v, 1'b1);
        probe(3'd0, 4'd2, v);
        check("R10 col2 bit7 low", v, 1'b0);
        check("R8 dip no irq", any_key_irq, 1'b0);
        dip_sw = 8'hFF;
        probe(3'd0, 4'd12, v);
        check("R6 col 12 reads 0", v, 1'b0);
        dip_sw = 8'h00;
    endtask

    task automatic t_timeout();
        logic v;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        repeat (3 * TMO) @(negedge clk);
        send_byte(8'h1C);
        probe(3'd4, 4'd1, v);
        check("R3 frame after stall", v, 1'b1);
        send_byte(8'hF0); send_byte(8'h1C);
        probe(3'd4, 4'd1, v);
        check("R3 release after stall", v, 1'b0);
    endtask

    task automatic t_autoscan();
        logic v;
        send_byte(8'h1C);
        @(negedge clk);
        row_sel = 3'd4;
        col_sel = 4'd1;
        autoscan = 1'b1;
        #1 check("R7 column input ignored", key_hit, 1'b0);
        pulse_clken();
        #1 check("R7 counter at 1", key_hit, 1'b1);
        pulse_clken();
        #1 check("R7 counter at 2", key_hit, 1'b0);
        for (int i = 0; i < 9; i++) pulse_clken();
        #1 check("R7 wrap back to 1", key_hit, 1'b1);
        @(negedge clk) autoscan = 1'b0;
        col_sel = 4'd5;
        @(negedge clk) clken_1m = 1'b1;
        @(negedge clk) clken_1m = 1'b0;
        autoscan = 1'b1;
        #1 check("R7 counter held while off", key_hit, 1'b1);
        @(negedge clk) autoscan = 1'b0;
        probe(3'd4, 4'd1, v);
    endtask

    task automatic t_reset_clears();
        logic v;
        send_byte(8'h07);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        probe(3'd4, 4'd1, v);
        check("R11 key cleared", v, 1'b0);
        check("R11 irq cleared", any_key_irq, 1'b0);
        check("R11 break cleared", break_key, 1'b0);
        send_byte(8'h29);
        probe(3'd6, 4'd2, v);
        check("R11 works after reset", v, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_press_release();
        t_bad_frames();
        t_extended();
        t_row0_and_break();
        t_dip();
        t_timeout();
        t_autoscan();
        t_reset_clears();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule